// File: doc/BRIEF.md
# Dual-Controller Bus Path Selector

This block joins one external processor bus to two internal controllers, a host-side controller and a device-side controller. On every cycle it decides which of them, if any, owns the shared data bus. The decision comes from a fixed priority order:

- While chip select is active, programmed I/O accesses are steered by one address line.
- While chip select is inactive, buffer transfers are steered by two DMA request/acknowledge pairs.
- When both DMA channels are fully active at once, the bus is shut off.

Each register access has two phases. A command phase names a register, and a data phase then moves the data. Which phase a cycle belongs to is set by a second address line. Each controller has stub registers and a stub buffer memory behind the selector, so that routing can be seen at the ports.

Top module: `bus_path_arbiter`

## Requirements
- R1: While `cs_n` is low, `a1`=0 selects the host path (`sel_host`=1) and `a1`=1 selects the device path (`sel_dev`=1). Both DMA acknowledges are ignored, and a DMA pair cannot change either controller.
- R2: While `cs_n` is high, `a1` is ignored. `req_h`&`ack_h` selects the host path and `req_d`&`ack_d` selects the device path.
- R3: An acknowledge whose own request is low selects nothing, and a write strobe given in that state changes no state.
- R4: With `cs_n` high and all four of `req_h`, `ack_h`, `req_d`, `ack_d` high, no path is selected, `bus_off` is 1, `rdata_oe` is 0 and a write strobe changes nothing.
- R5: `sel_host` and `sel_dev` are combinational from the inputs, and at most one of them is 1.
- R6: In a programmed I/O access, `a0`=1 is the command phase and `a0`=0 is the data phase. A command write latches `wdata[IW-1:0]` as that controller's register index, and a command read returns the latched index. Data-phase accesses use the latched index until the next command arrives. Each controller keeps its own index.
- R7: `rdata_oe` is 1 exactly when `rd_n`=0, `wr_n`=1 and one path is selected.
- R8: In each controller, index 2^IW−2 reads and writes the buffer pointer, and index 2^IW−1 is the buffer data port. Each data-port read or write uses the word at the pointer and then advances the pointer by one, wrapping modulo BDEPTH.
- R9: A DMA transfer reads or writes the selected controller's buffer word at its pointer and advances the pointer. It ignores `a0` and leaves the registers untouched.
- R10: A write takes effect at the rising clock edge where `wr_n`=0 and a path is selected. Reset clears the indices, pointers, registers and buffers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| a1 | input | 1 | Controller select for programmed I/O |
| a0 | input | 1 | Phase select: 1 command, 0 data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| req_h | input | 1 | DMA request, host channel |
| ack_h | input | 1 | DMA acknowledge, host channel |
| req_d | input | 1 | DMA request, device channel |
| ack_d | input | 1 | DMA acknowledge, device channel |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data from the selected controller |
| rdata_oe | output | 1 | Read data output enable |
| sel_host | output | 1 | Host path selected |
| sel_dev | output | 1 | Device path selected |
| bus_off | output | 1 | Bus shut off by the DMA clash |

## Verification
The selection outputs are swept over all 64 combinations of chip select, `a1` and the four DMA signals, once with the read strobe idle and once with it active. Comparing each result against a priority model separates chip-select priority, acknowledges without a request, and the four-signal clash. Directed sequences then cover the rest. Index latching in each controller separates the two controllers' state. Buffer pointer stepping and wrap, and DMA transfers in both directions, show which memory a transfer reaches. Writes given under an ignored acknowledge, under the clash, or with chip select overriding a live DMA pair are checked through the pointers read back afterwards.

// File: rtl/bus_path_arbiter.sv
module bus_path_arbiter #(
  parameter int DW     = 16,
  parameter int IW     = 4,
  parameter int BDEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          a1,
  input  logic          a0,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          req_h,
  input  logic          ack_h,
  input  logic          req_d,
  input  logic          ack_d,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  output logic          sel_host,
  output logic          sel_dev,
  output logic          bus_off
);
  localparam int NREG    = 2 ** IW;
  localparam int BW      = $clog2(BDEPTH);
  localparam int PTR_IDX = NREG - 2;
  localparam int BUF_IDX = NREG - 1;

  logic pio, dma_h, dma_d;
  logic [DW-1:0] rd_val [2];

  assign pio      = !cs_n;
  assign bus_off  = cs_n & req_h & ack_h & req_d & ack_d;
  assign dma_h    = cs_n & req_h & ack_h & !bus_off;
  assign dma_d    = cs_n & req_d & ack_d & !bus_off;
  assign sel_host = (pio & !a1) | dma_h;
  assign sel_dev  = (pio & a1) | dma_d;
  assign rdata_oe = !rd_n & wr_n & (sel_host ^ sel_dev);
  assign rdata    = sel_dev ? rd_val[1] : rd_val[0];

  for (genvar c = 0; c < 2; c++) begin : g_ctl
    logic          hit, pio_c, dma_c, wr_c, rd_c, cmd_c, buf_acc;
    logic [IW-1:0] idx;
    logic [BW-1:0] ptr;
    logic [DW-1:0] regs [NREG];
    logic [DW-1:0] mem  [BDEPTH];

    assign hit     = (c == 1) ? sel_dev : sel_host;
    assign pio_c   = hit & pio;
    assign dma_c   = hit & !pio;
    assign wr_c    = hit & !wr_n;
    assign rd_c    = hit & !rd_n & wr_n;
    assign cmd_c   = pio_c & a0;
    assign buf_acc = dma_c | (pio_c & !a0 & (idx == IW'(BUF_IDX)));

    always_comb begin
      if (cmd_c)                     rd_val[c] = DW'(idx);
      else if (buf_acc)              rd_val[c] = mem[ptr];
      else if (idx == IW'(PTR_IDX))  rd_val[c] = DW'(ptr);
      else                           rd_val[c] = regs[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx <= '0;
        ptr <= '0;
        for (int i = 0; i < NREG; i++)   regs[i] <= '0;
        for (int i = 0; i < BDEPTH; i++) mem[i]  <= '0;
      end else if (wr_c) begin
        if (cmd_c) idx <= wdata[IW-1:0];
        else if (buf_acc) begin
          mem[ptr] <= wdata;
          ptr      <= ptr + 1'b1;
        end
        else if (idx == IW'(PTR_IDX)) ptr <= wdata[BW-1:0];
        else regs[idx] <= wdata;
      end else if (rd_c && buf_acc) begin
        ptr <= ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_path_arbiter_chk.sv
module bus_path_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic a1,
  input logic rd_n,
  input logic wr_n,
  input logic req_h,
  input logic ack_h,
  input logic req_d,
  input logic ack_d,
  input logic rdata_oe,
  input logic sel_host,
  input logic sel_dev,
  input logic bus_off
);
  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_host, sel_dev}));

  // R1
  cs_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (sel_host == !a1) && (sel_dev == a1) && !bus_off);

  // R3
  lone_ack_h_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !req_h) |-> !sel_host);

  // R3
  lone_ack_d_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !req_d) |-> !sel_dev);

  // R4
  clash_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && req_h && ack_h && req_d && ack_d) |-> bus_off && !sel_host && !sel_dev && !rdata_oe);

  // R7
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> !rd_n && wr_n && (sel_host || sel_dev));

  // R7
  oe_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && wr_n && (sel_host || sel_dev)) |-> rdata_oe);
endmodule

bind bus_path_arbiter bus_path_arbiter_chk u_chk (.*);

// File: tb/bus_path_arbiter_tb.sv
`timescale 1ns/1ps
module bus_path_arbiter_tb;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, a1 = 0, a0 = 0, rd_n = 1, wr_n = 1;
  logic req_h = 0, ack_h = 0, req_d = 0, ack_d = 0;
  logic [15:0] wdata = 0, rdata, q;
  logic rdata_oe, sel_host, sel_dev, bus_off;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bus_path_arbiter u_dut (.*);

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pio_wr(input logic sa1, input logic sa0, input logic [15:0] d);
    @(negedge clk); cs_n = 0; a1 = sa1; a0 = sa0; wdata = d; wr_n = 0;
    @(negedge clk); wr_n = 1; cs_n = 1;
  endtask

  task automatic pio_rd(input logic sa1, input logic sa0, output logic [15:0] d);
    @(negedge clk); cs_n = 0; a1 = sa1; a0 = sa0; rd_n = 0;
    #1 d = rdata;
    @(negedge clk); rd_n = 1; cs_n = 1;
  endtask

  task automatic set_dma(input int ch, input logic v);
    if (ch == 1) begin req_h = v; ack_h = v; end
    else begin req_d = v; ack_d = v; end
  endtask

  task automatic dma_wr(input int ch, input logic [15:0] d);
    @(negedge clk); cs_n = 1; set_dma(ch, 1); wdata = d; wr_n = 0;
    @(negedge clk); wr_n = 1; set_dma(ch, 0);
  endtask

  task automatic dma_rd(input int ch, output logic [15:0] d);
    @(negedge clk); cs_n = 1; set_dma(ch, 1); rd_n = 0;
    #1 d = rdata;
    @(negedge clk); rd_n = 1; set_dma(ch, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 R2 R3 R4 R5 R7: full sweep against priority model
    for (int r = 0; r < 2; r++) begin
      for (int v = 0; v < 64; v++) begin
        logic c, s1, rh, ah, rd, ad, eh, ed, eo, ee;
        {c, s1, rh, ah, rd, ad} = 6'(v);
        @(negedge clk);
        cs_n = c; a1 = s1; req_h = rh; ack_h = ah; req_d = rd; ack_d = ad;
        rd_n = (r == 0);
        eo = c & rh & ah & rd & ad;
        eh = !c ? !s1 : (rh & ah & !eo);
        ed = !c ? s1 : (rd & ad & !eo);
        ee = !rd_n & (eh ^ ed);
        #1 chk("R1/R2/R3/R4/R7 sweep", 16'({sel_host, sel_dev, bus_off, rdata_oe}),
               16'({eh, ed, eo, ee}));
      end
    end
    @(negedge clk);
    cs_n = 1; rd_n = 1; {req_h, ack_h, req_d, ack_d} = 0;
    rst_n = 0;
    @(negedge clk); rst_n = 1;

    // R10 reset state
    pio_rd(0, 1, q); chk("R10 host index reset", q, 0);
    pio_rd(1, 0, q); chk("R10 dev reg0 reset", q, 0);

    // R6 per-controller index and data
    pio_wr(0, 1, 3); pio_wr(0, 0, 16'h1234);
    pio_wr(1, 1, 3); pio_wr(1, 0, 16'hBEEF);
    pio_rd(0, 0, q); chk("R6 host reg3", q, 16'h1234);
    pio_rd(1, 0, q); chk("R6 dev reg3", q, 16'hBEEF);
    pio_rd(0, 1, q); chk("R6 host index readback", q, 3);
    pio_rd(0, 0, q); chk("R6 index held", q, 16'h1234);

    // R8 buffer port and pointer
    pio_wr(0, 1, 14); pio_wr(0, 0, 5);
    pio_wr(0, 1, 15); pio_wr(0, 0, 16'h00AA); pio_wr(0, 0, 16'h00BB);
    pio_wr(0, 1, 14); pio_rd(0, 0, q); chk("R8 pointer after two writes", q, 7);
    pio_wr(0, 0, 5); pio_wr(0, 1, 15);
    pio_rd(0, 0, q); chk("R8 buffer word 5", q, 16'h00AA);
    pio_rd(0, 0, q); chk("R8 buffer word 6", q, 16'h00BB);
    pio_wr(0, 1, 14); pio_wr(0, 0, 15);
    pio_wr(0, 1, 15); pio_wr(0, 0, 16'h0F0F);
    pio_wr(0, 1, 14); pio_rd(0, 0, q); chk("R8 pointer wrap", q, 0);

    // R9 DMA into device buffer
    pio_wr(1, 1, 14); pio_wr(1, 0, 0);
    dma_wr(2, 16'h1111); dma_wr(2, 16'h2222); dma_wr(2, 16'h3333);
    pio_rd(1, 0, q); chk("R9 dev pointer after DMA", q, 3);
    pio_wr(1, 0, 0); pio_wr(1, 1, 15);
    pio_rd(1, 0, q); chk("R9 dev buf 0", q, 16'h1111);
    pio_rd(1, 0, q); chk("R9 dev buf 1", q, 16'h2222);
    pio_rd(1, 0, q); chk("R9 dev buf 2", q, 16'h3333);
    pio_wr(1, 1, 3); pio_rd(1, 0, q); chk("R9 dev reg3 untouched", q, 16'hBEEF);
    pio_wr(0, 1, 14); pio_wr(0, 0, 5);
    dma_rd(1, q); chk("R9 host DMA read", q, 16'h00AA);
    pio_rd(0, 0, q); chk("R9 host pointer after DMA read", q, 6);

    // R3 lone acknowledge write ignored
    @(negedge clk); cs_n = 1; ack_h = 1; req_h = 0; ack_d = 1; wdata = 16'h5555; wr_n = 0;
    @(negedge clk); wr_n = 1; ack_h = 0; ack_d = 0;
    pio_rd(0, 0, q); chk("R3 host pointer unchanged", q, 6);

    // R4 clash write ignored
    @(negedge clk); cs_n = 1; {req_h, ack_h, req_d, ack_d} = 4'hF; wdata = 16'h7777; wr_n = 0;
    @(negedge clk); wr_n = 1; {req_h, ack_h, req_d, ack_d} = 0;
    pio_rd(0, 0, q); chk("R4 host pointer unchanged", q, 6);
    pio_wr(1, 1, 14); pio_rd(1, 0, q); chk("R4 dev pointer unchanged", q, 3);

    // R1 chip select overrides live DMA pair
    @(negedge clk); cs_n = 0; a1 = 0; a0 = 1; req_d = 1; ack_d = 1; wdata = 16'd2; wr_n = 0;
    @(negedge clk); wr_n = 1; cs_n = 1; req_d = 0; ack_d = 0;
    pio_rd(1, 0, q); chk("R1 dev pointer unchanged under cs", q, 3);
    pio_rd(0, 1, q); chk("R1 host got command", q, 2);

    // R10 write with no path selected
    @(negedge clk); cs_n = 1; wdata = 16'h9999; wr_n = 0;
    @(negedge clk); wr_n = 1;
    pio_rd(0, 1, q); chk("R10 idle write no effect", q, 2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule